// File: doc/BRIEF.md
# Two-Line Load Prefetch Buffer

This block sits between a processor load port and an external memory bus. It keeps two lines of four 64-bit double words. Each line has one address tag and one valid bit. A cacheable load that matches a valid tag is served from the buffer and causes no memory traffic. A cacheable load that matches neither line triggers a four-beat burst read. The read refills the least-recently-used line and forwards the requested double word.

Loads marked non-cacheable, and atomic load-store accesses in any region, bypass the buffer and fetch one double word from memory. If such an access matches a buffered line, that line is dropped so that the buffer never holds stale data. A flush input drops both lines at once.

Both data-carrying interfaces follow valid/ready rules:
- **Load request:** the block accepts one load at a time. `req_ready` is high only when the block is idle, and it stays low until the response has been taken.
- **Response:** once `rsp_valid` rises, it stays high and `rsp_data` stays stable until `rsp_ready` is seen.
- **Memory request:** `mem_req_valid` stays high with a stable address and burst flag until `mem_req_ready`.
- **Memory read beats:** these carry a strobe only. The block always accepts them.

Top module: `rb_prefetch_buf`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and both lines are invalid, so the first cacheable load misses.
- R2: A cacheable load whose line is valid returns the buffered double word with no memory request. `rsp_valid` rises in the cycle after the load is accepted.
- R3: A cacheable miss issues exactly one request with `mem_req_burst`=1 and `mem_req_addr` equal to the load's byte address. Four beats follow. Beat k holds the double word at index (requested index + k) mod 4 within the 32-byte line, where the index is address bits [4:3]. The response data is the first beat.
- R4: A line becomes valid only after its fourth beat. Afterwards, cacheable loads to any of its four double words hit.
- R5: A miss refills the line that was not used most recently. Both hits and refills count as a use.
- R6: A non-cacheable load (`req_nocache`=1) issues one request with `mem_req_burst`=0 and returns the single beat. If its address matches a valid line, that line becomes invalid.
- R7: An atomic load (`req_atomic`=1) behaves exactly like a non-cacheable load, whatever the value of `req_nocache`.
- R8: A one-cycle pulse on `flush` while the block is idle invalidates both lines.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` is unchanged. `req_ready` is 0 from acceptance until the response is taken.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate both lines |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Load request accepted when high with req_valid |
| req_addr | input | ADDR_W | Load byte address |
| req_nocache | input | 1 | Load targets a non-cacheable region |
| req_atomic | input | 1 | Load is part of an atomic access |
| rsp_valid | output | 1 | Response data valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_data | output | DATA_W | Requested double word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Requested byte address (bits below the double word ignored) |
| mem_req_burst | output | 1 | 1: four wrapping beats, 0: one beat |
| mem_rvalid | input | 1 | Read beat strobe |
| mem_rdata | input | DATA_W | Read beat data |

## Verification
The assertions assume the following of the memory side:
- It sends read beats only after it has accepted a request.
- It sends exactly four beats for a burst and one beat for a single read.
- Burst beats arrive in wrapping order.
- It never sends a beat while a request is still pending.

The assertions also assume that the load fields stay steady while `req_valid` is high. The bench memory model keeps to these rules. It inserts random wait cycles before accepting a request and between beats, but it never sends an unrequested or extra beat. The stimulus applies `flush` only between loads.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_MREQ  = 2'd1,
    S_MWAIT = 2'd2,
    S_RESP  = 2'd3
  } rb_state_e;
endpackage

// File: rtl/rb_tags.sv
module rb_tags #(
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic [1:0]       hit,
  output logic             lru,
  input  logic             touch_en,
  input  logic             touch_line,
  input  logic             alloc_en,
  input  logic             alloc_line,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             inv_en,
  input  logic             inv_line,
  input  logic             fill_en,
  input  logic             fill_line
);
  localparam int LINES = 2;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic             lru_q;

  for (genvar l = 0; l < LINES; l++) begin : g_cmp
    assign hit[l] = valid_q[l] && (tag_q[l] == lookup_tag);
  end

  assign lru = lru_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      lru_q   <= 1'b0;
      for (int l = 0; l < LINES; l++) tag_q[l] <= '0;
    end else begin
      if (alloc_en) begin
        tag_q[alloc_line]   <= alloc_tag;
        valid_q[alloc_line] <= 1'b0;
      end
      if (inv_en)   valid_q[inv_line] <= 1'b0;
      if (fill_en)  valid_q[fill_line] <= 1'b1;
      if (flush)    valid_q <= '0;
      if (fill_en)       lru_q <= ~fill_line;
      else if (touch_en) lru_q <= ~touch_line;
    end
  end

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  p_lru_away_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en || touch_en) |=> (lru_q != $past(fill_en ? fill_line : touch_line)));
endmodule

// File: rtl/rb_data.sv
module rb_data #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic                     wr_line,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_line,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int LINES = 2;

  logic [DATA_W-1:0] arr_q [LINES][WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) arr_q[wr_line][wr_idx] <= wr_data;
  end

  assign rd_data = arr_q[rd_line][rd_idx];
endmodule

// File: rtl/rb_prefetch_buf.sv
module rb_prefetch_buf
  import rb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_nocache,
  input  logic              req_atomic,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_burst,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - WIDX_W - OFF_W;

  rb_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              burst_q;
  logic              vic_q;
  logic [WIDX_W-1:0] beat_q;
  logic [DATA_W-1:0] rsp_q;

  logic [1:0]        hit;
  logic              hit_any, hit_line, lru;
  logic              req_fire, cached;
  logic [DATA_W-1:0] buf_rd;
  logic              beat_in, last_beat;
  logic [WIDX_W-1:0] wr_idx;

  assign req_ready     = (state_q == S_IDLE);
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp_data      = rsp_q;
  assign mem_req_valid = (state_q == S_MREQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_burst = burst_q;

  assign req_fire  = req_valid && req_ready;
  assign cached    = !req_nocache && !req_atomic;
  assign hit_any   = |hit;
  assign hit_line  = hit[1];
  assign beat_in   = (state_q == S_MWAIT) && mem_rvalid;
  assign last_beat = !burst_q || (beat_q == WIDX_W'(WORDS - 1));
  assign wr_idx    = addr_q[OFF_W +: WIDX_W] + beat_q;

  rb_tags #(.TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lookup_tag (req_addr[ADDR_W-1 -: TAG_W]),
    .hit        (hit),
    .lru        (lru),
    .touch_en   (req_fire && cached && hit_any),
    .touch_line (hit_line),
    .alloc_en   (req_fire && cached && !hit_any),
    .alloc_line (lru),
    .alloc_tag  (req_addr[ADDR_W-1 -: TAG_W]),
    .inv_en     (req_fire && !cached && hit_any),
    .inv_line   (hit_line),
    .fill_en    (beat_in && burst_q && last_beat),
    .fill_line  (vic_q)
  );

  rb_data #(.DATA_W(DATA_W), .WORDS(WORDS)) u_data (
    .clk     (clk),
    .wr_en   (beat_in && burst_q),
    .wr_line (vic_q),
    .wr_idx  (wr_idx),
    .wr_data (mem_rdata),
    .rd_line (hit_line),
    .rd_idx  (req_addr[OFF_W +: WIDX_W]),
    .rd_data (buf_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      burst_q <= 1'b0;
      vic_q   <= 1'b0;
      beat_q  <= '0;
      rsp_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_fire) begin
          addr_q <= req_addr;
          beat_q <= '0;
          if (cached && hit_any) begin
            rsp_q   <= buf_rd;
            state_q <= S_RESP;
          end else begin
            burst_q <= cached;
            vic_q   <= lru;
            state_q <= S_MREQ;
          end
        end
        S_MREQ:  if (mem_req_ready) state_q <= S_MWAIT;
        S_MWAIT: if (mem_rvalid) begin
          if (beat_q == '0) rsp_q <= mem_rdata;
          beat_q <= beat_q + WIDX_W'(1);
          if (last_beat) state_q <= S_RESP;
        end
        S_RESP:  if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_mreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_hit_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && cached && hit_any) |=> (rsp_valid && !mem_req_valid));
  p_bypass_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !cached) |=> (mem_req_valid && !mem_req_burst));
endmodule

// File: tb/test_rb_prefetch_buf.sv
`timescale 1ns/1ps
module test_rb_prefetch_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0, req_nocache = 1'b0, req_atomic = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_data;
  logic        mem_req_valid, mem_req_burst;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  rb_prefetch_buf i_rb_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_nocache(req_nocache), .req_atomic(req_atomic),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_burst(mem_req_burst),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int tests = 0, fails = 0, cyc = 0;
  int req_cnt = 0;
  logic [31:0] last_addr = '0;
  logic        last_burst = 1'b0;
  logic [31:0] epoch = 32'h1357_9bdf;
  int unsigned seed = 32'h2468_ace1;

  logic [26:0] m_tag [2];
  bit          m_val [2];
  bit          m_lru;
  logic [63:0] m_dat [2][4];

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  function automatic logic [63:0] memval(input logic [31:0] a);
    logic [31:0] d;
    d = {a[31:3], 3'b000};
    return {d, d ^ epoch};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model: random accept delay, wrapping beats with random bubbles
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [31:0] a;
        logic        b;
        repeat (rnd() % 3) @(negedge clk);
        a = mem_req_addr;
        b = mem_req_burst;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        req_cnt++;
        last_addr = a;
        last_burst = b;
        for (int k = 0; k < (b ? 4 : 1); k++) begin
          logic [1:0] w;
          repeat (rnd() % 2) @(negedge clk);
          w = a[4:3] + 2'(k);
          mem_rvalid = 1'b1;
          mem_rdata = memval({a[31:5], w, 3'b000});
          @(negedge clk);
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  // per-clock handshake monitor (R9, R10)
  logic        p_rv = 1'b0, p_rr = 1'b0, p_mv = 1'b0, p_mr = 1'b0;
  logic [63:0] p_rd = '0;
  logic [31:0] p_ma = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_rv && !p_rr) chk(rsp_valid && rsp_data == p_rd, "R9 response held", rsp_data, p_rd);
      if (p_mv && !p_mr) chk(mem_req_valid && mem_req_addr == p_ma, "R10 request held",
                             {31'b0, mem_req_valid}, 64'd1);
    end
    p_rv = rsp_valid; p_rr = rsp_ready; p_rd = rsp_data;
    p_mv = mem_req_valid; p_mr = mem_req_ready; p_ma = mem_req_addr;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic do_load(input logic [31:0] a, input bit nc, input bit at,
                         input int hold, input string tag);
    logic [63:0] exp_d;
    int          hl, n0;
    bit          byp, exp_burst, exp_req;
    byp = nc || at;
    hl = -1;
    for (int l = 0; l < 2; l++) if (m_val[l] && m_tag[l] == a[31:5]) hl = l;
    if (byp) begin
      if (hl >= 0) m_val[hl] = 0;
      exp_d = memval(a); exp_req = 1; exp_burst = 0;
    end else if (hl >= 0) begin
      exp_d = m_dat[hl][a[4:3]]; m_lru = (hl == 0); exp_req = 0; exp_burst = 0;
    end else begin
      int v;
      v = m_lru;
      m_tag[v] = a[31:5]; m_val[v] = 1; m_lru = (v == 0);
      for (int k = 0; k < 4; k++) m_dat[v][k] = memval({a[31:5], 2'(k), 3'b000});
      exp_d = memval(a); exp_req = 1; exp_burst = 1;
    end
    n0 = req_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_nocache = nc; req_atomic = at;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {tag, " R9 busy"}, {63'b0, req_ready}, 64'd0);
    if (!byp && hl >= 0) chk(rsp_valid, {tag, " R2 one-cycle hit"}, {63'b0, rsp_valid}, 64'd1);
    while (!rsp_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    chk(rsp_data == exp_d, {tag, " data"}, rsp_data, exp_d);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk((req_cnt - n0) == int'(exp_req), {tag, " request count"}, 64'(req_cnt - n0), 64'(exp_req));
    if (exp_req) begin
      chk(last_addr == a, {tag, " request address"}, {32'b0, last_addr}, {32'b0, a});
      chk(last_burst == exp_burst, {tag, " burst flag"}, {63'b0, last_burst}, {63'b0, exp_burst});
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_val[0] = 0; m_val[1] = 0;
  endtask

  initial begin
    m_val[0] = 0; m_val[1] = 0; m_lru = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
        {61'b0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

    do_load(32'h0000_0110, 0, 0, 0, "R1 R3 first miss wraps from word 2");
    do_load(32'h0000_0100, 0, 0, 0, "R4 hit word 0");
    do_load(32'h0000_0118, 0, 0, 2, "R4 R9 hit word 3 with back-pressure");
    do_load(32'h0000_0108, 0, 0, 0, "R2 hit word 1");
    do_load(32'h0000_0208, 0, 0, 1, "R5 second line fill");
    do_load(32'h0000_0100, 0, 0, 0, "R5 touch first line");
    do_load(32'h0000_0318, 0, 0, 0, "R5 evicts second line");
    do_load(32'h0000_0110, 0, 0, 0, "R5 first line kept");
    do_load(32'h0000_0200, 0, 0, 0, "R5 evicted line misses");
    epoch = epoch ^ 32'h00ff_00ff;
    do_load(32'h0000_0218, 0, 0, 0, "R2 hit returns buffered data");
    do_load(32'h0000_0210, 1, 0, 0, "R6 non-cacheable bypass");
    do_load(32'h0000_0200, 0, 0, 0, "R6 invalidated line misses");
    do_load(32'h0000_0208, 0, 1, 3, "R7 atomic bypass");
    do_load(32'h0000_0208, 0, 0, 0, "R7 atomic invalidated line");
    do_load(32'h0000_5000, 1, 1, 0, "R7 atomic non-cacheable miss");
    do_flush();
    do_load(32'h0000_0208, 0, 0, 0, "R8 flushed line misses");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      int r;
      r = rnd();
      a = {16'h0, 4'(r % 5), 7'(0), 2'((r >> 4) % 2), 2'((r >> 6) % 4), 3'b000};
      if (rnd() % 16 == 0) do_flush();
      if (rnd() % 8 == 0) epoch = epoch + 32'h1111;
      do_load(a, (rnd() % 8) == 0, (rnd() % 9) == 0, rnd() % 3, "R5 R6 mixed traffic");
    end

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule